// File: doc/BRIEF.md
# Output Scaling and Rounding Stage

This stage takes a wide result from a filter datapath and narrows it to a smaller output word. It removes the low `IN_W - OUT_W` bits, which divides the value by a power of two. A build-time parameter selects how the removed bits are treated. Truncation always moves the result toward minus infinity. Round-to-nearest moves it to the closest output step, and an exact half step goes upward.

A second parameter selects whether the words are read as two's-complement or as unsigned. Rounding up can push a value past the largest output code. In that case the output is clamped at the largest code instead of wrapping around.

The narrowed value is stored in an output register. Its valid flag is the input strobe delayed by one clock. While no strobe arrives, the register keeps its contents. A synchronous active-low reset clears both the value and the flag.

Top module: `scl_round_stage`

## Requirements
- R1: In truncation mode with signed data, a strobed input x gives `floor(x / 2^(IN_W-OUT_W))` as a two's-complement OUT_W-bit code one clock later. With widths 8 and 6, input 0xA9 (-87) gives 0x2A (-22), and input 0xAB (-85) also gives 0x2A (-22).
- R2: In truncation mode with unsigned data, the output is the upper OUT_W bits of the input. With widths 8 and 6, input 169 gives 42 and input 171 gives 42.
- R3: In nearest mode with signed data, the output is `floor((x + 2^(IN_W-OUT_W-1)) / 2^(IN_W-OUT_W))`, so an exact half step rounds up. With widths 8 and 6, input -87 gives -22, -85 gives -21 and +2 gives 1.
- R4: In nearest mode with unsigned data, the same half-up rule applies to unsigned values. With widths 8 and 6, input 169 gives 42, 171 gives 43 and 2 gives 1.
- R5: In nearest mode, a rounded value above the largest OUT_W-bit code is clamped to that code. The largest code is `2^(OUT_W-1)-1` for signed data and all ones for unsigned data. With widths 8 and 6, signed 0x7F gives 31 and unsigned 0xFE gives 63.
- R6: `out_valid` equals `in_valid` delayed by exactly one clock.
- R7: A clock edge with `reset_n` low sets `out_valid` to 0 and `out_data` to 0.
- R8: A cycle with `in_valid` low leaves `out_data` unchanged, whatever `in_data` holds.
- R9: When `OUT_W` equals `IN_W`, the input passes unchanged to the output register in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| reset_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_data` as a sample to be scaled |
| in_data | input | IN_W | Full-width value, signed or unsigned per `SIGNED_DATA` |
| out_valid | output | 1 | Registered valid flag, one clock after `in_valid` |
| out_data | output | OUT_W | Registered scaled and rounded value |

## Verification
One stimulus stream is applied to four copies of the stage at the same time, one per combination of mode and signedness, plus a copy with equal widths. Each input pattern is chosen to make the copies disagree in a particular way:
- Values whose dropped bits are below a half step show that both modes agree.
- Exact half steps, such as 2 and -126, separate truncation from half-up rounding.
- Negative values separate floor behaviour from rounding toward zero, and show the signed copies diverging from the unsigned ones on the same bits.
- Values near the top of each range, such as 0x7E, 0x7F, 0xFE and 0xFF, show clamping against wrap-around.
- Values near the bottom, such as 0x80, show that the most negative code is never clamped.

Idle cycles carrying changed data and a mid-stream reset expose a register that loads without a strobe or fails to clear.

// File: rtl/scl_pkg.sv
// Package: shared types for the output scaling and rounding stage.
// Assumes nothing beyond standard SystemVerilog enums.
package scl_pkg;

    // How the dropped low bits are treated.
    typedef enum logic {
        RND_TRUNC   = 1'b0,   // floor toward minus infinity
        RND_NEAREST = 1'b1    // nearest step, half step goes up
    } round_mode_e;

endpackage

// File: rtl/scl_bias_add.sv
// Module: scl_bias_add
// Extends the input by one bit (sign or zero) and adds half of an output
// step, so that a later bit drop yields round-half-up.
// Assumes DROP >= 1; it is only instantiated in that case.
module scl_bias_add #(
    parameter int IN_W        = 8,
    parameter int DROP        = 2,
    parameter bit SIGNED_DATA = 1'b1
) (
    input  logic [IN_W-1:0] raw_in,
    output logic [IN_W:0]   biased_out
);

    localparam int          SUM_W = IN_W + 1;
    localparam logic [IN_W:0] HALF_STEP = SUM_W'(1) << (DROP - 1);

    logic [IN_W:0] widened;

    // Widen by one bit according to the number interpretation.
    always_comb begin
        if (SIGNED_DATA) begin
            widened = {raw_in[IN_W-1], raw_in};
        end else begin
            widened = {1'b0, raw_in};
        end
    end

    // Add the half-step bias; the extra bit absorbs the carry.
    always_comb begin
        biased_out = widened + HALF_STEP;
    end

endmodule

// File: rtl/scl_clip.sv
// Module: scl_clip
// Drops the low DROP bits of the biased sum and clamps results that rose
// above the largest OUT_W-bit code. Adding a positive bias can only push a
// value up, so only the upper limit needs a clamp.
// Assumes SUM_W == OUT_W + DROP + 1.
module scl_clip #(
    parameter int SUM_W       = 9,
    parameter int OUT_W       = 6,
    parameter int DROP        = 2,
    parameter bit SIGNED_DATA = 1'b1
) (
    input  logic [SUM_W-1:0] biased_in,
    output logic [OUT_W-1:0] clipped_out
);

    localparam logic [OUT_W-1:0] SMAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] UMAX = {OUT_W{1'b1}};

    logic [OUT_W:0] shifted;
    logic           over_top;

    // Keep the upper bits of the biased sum.
    always_comb begin
        shifted = biased_in[SUM_W-1:DROP];
    end

    // Detect values beyond the largest code for the chosen interpretation.
    always_comb begin
        if (SIGNED_DATA) begin
            over_top = (shifted[OUT_W:OUT_W-1] == 2'b01);
        end else begin
            over_top = shifted[OUT_W];
        end
    end

    // Pick the clamp value or the narrowed bits.
    always_comb begin
        if (over_top) begin
            clipped_out = SIGNED_DATA ? SMAX : UMAX;
        end else begin
            clipped_out = shifted[OUT_W-1:0];
        end
    end

    // A positive bias must never produce a value below the signed minimum.
    always_comb begin
        if (SIGNED_DATA) begin
            AST_NO_UNDERFLOW: assert (shifted[OUT_W:OUT_W-1] != 2'b10); // R5
        end
    end

endmodule

// File: rtl/scl_out_reg.sv
// Module: scl_out_reg
// Output register with valid flag. Data loads only on a strobe; the flag
// is the strobe delayed by one clock. Synchronous active-low reset.
module scl_out_reg #(
    parameter int OUT_W = 6
) (
    input  logic             clk,
    input  logic             reset_n,
    input  logic             load_en,
    input  logic [OUT_W-1:0] next_val,
    output logic             q_valid,
    output logic [OUT_W-1:0] q_data
);

    // Register the scaled value and its valid flag.
    always_ff @(posedge clk) begin
        if (!reset_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= load_en;
            if (load_en) begin
                q_data <= next_val;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!reset_n)
        load_en |=> q_valid); // R6

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!reset_n)
        !load_en |=> !q_valid); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!reset_n)
        !load_en |=> $stable(q_data)); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !reset_n |=> (!q_valid && (q_data == '0))); // R7

endmodule

// File: rtl/scl_round_stage.sv
// Module: scl_round_stage (top)
// Narrows an IN_W-bit value to OUT_W bits by dropping the low bits. The
// dropped bits are either truncated (floor) or rounded half-up with
// saturation at the top code. The result is registered.
// Assumes OUT_W <= IN_W and that both parameters are at least 2.
module scl_round_stage
    import scl_pkg::*;
#(
    parameter int          IN_W        = 8,
    parameter int          OUT_W       = 6,
    parameter round_mode_e MODE        = RND_NEAREST,
    parameter bit          SIGNED_DATA = 1'b1
) (
    input  logic             clk,
    input  logic             reset_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);

    localparam int DROP = IN_W - OUT_W;
    localparam int EW   = IN_W + 2;
    localparam int OMAG = SIGNED_DATA ? OUT_W - 1 : OUT_W;
    localparam logic signed [EW-1:0] STEP    = EW'(1) <<< DROP;
    localparam logic signed [EW-1:0] HALF    = STEP >>> 1;
    localparam logic signed [EW-1:0] OMAX_SC = ((EW'(1) <<< OMAG) - EW'(1)) <<< DROP;

    logic [OUT_W-1:0] scaled_next;

    // Choose the narrowing path from the parameters.
    generate
        if (DROP == 0) begin : g_pass
            assign scaled_next = in_data;
        end else if (MODE == RND_TRUNC) begin : g_trunc
            assign scaled_next = in_data[IN_W-1:DROP];
        end else begin : g_near
            logic [IN_W:0] biased;
            scl_bias_add #(
                .IN_W        (IN_W),
                .DROP        (DROP),
                .SIGNED_DATA (SIGNED_DATA)
            ) u_bias (
                .raw_in     (in_data),
                .biased_out (biased)
            );
            scl_clip #(
                .SUM_W       (IN_W + 1),
                .OUT_W       (OUT_W),
                .DROP        (DROP),
                .SIGNED_DATA (SIGNED_DATA)
            ) u_clip (
                .biased_in   (biased),
                .clipped_out (scaled_next)
            );
        end
    endgenerate

    scl_out_reg #(
        .OUT_W (OUT_W)
    ) u_oreg (
        .clk      (clk),
        .reset_n  (reset_n),
        .load_en  (in_valid),
        .next_val (scaled_next),
        .q_valid  (out_valid),
        .q_data   (out_data)
    );

    // Checking aid: the input and the output at a common scale, as integers.
    logic signed [EW-1:0] in_ext;
    logic signed [EW-1:0] out_scaled;

    // Widen the input to the checking width.
    always_comb begin
        if (SIGNED_DATA) begin
            in_ext = {{2{in_data[IN_W-1]}}, in_data};
        end else begin
            in_ext = {2'b00, in_data};
        end
    end

    // Widen the output and restore the dropped weight.
    always_comb begin
        if (SIGNED_DATA) begin
            out_scaled = {{(DROP+2){out_data[OUT_W-1]}}, out_data} <<< DROP;
        end else begin
            out_scaled = {{(DROP+2){1'b0}}, out_data} <<< DROP;
        end
    end

    generate
        if (DROP == 0) begin : g_chk_pass
            AST_PASS_EXACT: assert property (@(posedge clk) disable iff (!reset_n)
                in_valid |=> (out_scaled == $past(in_ext))); // R9
        end else if (MODE == RND_TRUNC) begin : g_chk_trunc
            AST_TRUNC_FLOOR: assert property (@(posedge clk) disable iff (!reset_n)
                in_valid |=> ((out_scaled <= $past(in_ext)) &&
                              (($past(in_ext) - out_scaled) < STEP))); // R1
        end else begin : g_chk_near
            AST_NEAR_ERROR: assert property (@(posedge clk) disable iff (!reset_n)
                in_valid |=> ((out_scaled == OMAX_SC) ||
                              (((out_scaled - $past(in_ext)) <= HALF) &&
                               (($past(in_ext) - out_scaled) < HALF)))); // R3
            AST_NEAR_SATURATE: assert property (@(posedge clk) disable iff (!reset_n)
                (in_valid && ((in_ext + HALF) >= (OMAX_SC + STEP)))
                |=> (out_scaled == OMAX_SC)); // R5
        end
    endgenerate

endmodule

// File: tb/scl_round_stage_tb.sv
module scl_round_stage_tb;
    import scl_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] din;
        logic [5:0] st;
        logic [5:0] sn;
        logic [5:0] ut;
        logic [5:0] un;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'hA9, 6'd42, 6'd42, 6'd42, 6'd42},
        '{8'hAB, 6'd42, 6'd43, 6'd42, 6'd43},
        '{8'h00, 6'd0,  6'd0,  6'd0,  6'd0 },
        '{8'h02, 6'd0,  6'd1,  6'd0,  6'd1 },
        '{8'h01, 6'd0,  6'd0,  6'd0,  6'd0 },
        '{8'h7F, 6'd31, 6'd31, 6'd31, 6'd32},
        '{8'h7D, 6'd31, 6'd31, 6'd31, 6'd31},
        '{8'hFF, 6'd63, 6'd0,  6'd63, 6'd63},
        '{8'hFE, 6'd63, 6'd0,  6'd63, 6'd63},
        '{8'h80, 6'd32, 6'd32, 6'd32, 6'd32},
        '{8'h82, 6'd32, 6'd33, 6'd32, 6'd33},
        '{8'h7E, 6'd31, 6'd31, 6'd31, 6'd32},
        '{8'hFD, 6'd63, 6'd63, 6'd63, 6'd63},
        '{8'h3A, 6'd14, 6'd15, 6'd14, 6'd15}
    };

    logic       clk = 1'b0;
    logic       reset_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       v_sn, v_st, v_un, v_ut, v_eq;
    logic [5:0] o_sn, o_st, o_un, o_ut;
    logic [7:0] o_eq;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_round_stage #(.IN_W(8), .OUT_W(6), .MODE(RND_NEAREST), .SIGNED_DATA(1'b1)) u_dut (
        .clk(clk), .reset_n(reset_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v_sn), .out_data(o_sn));
    scl_round_stage #(.IN_W(8), .OUT_W(6), .MODE(RND_TRUNC), .SIGNED_DATA(1'b1)) u_dut_st (
        .clk(clk), .reset_n(reset_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v_st), .out_data(o_st));
    scl_round_stage #(.IN_W(8), .OUT_W(6), .MODE(RND_NEAREST), .SIGNED_DATA(1'b0)) u_dut_un (
        .clk(clk), .reset_n(reset_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v_un), .out_data(o_un));
    scl_round_stage #(.IN_W(8), .OUT_W(6), .MODE(RND_TRUNC), .SIGNED_DATA(1'b0)) u_dut_ut (
        .clk(clk), .reset_n(reset_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v_ut), .out_data(o_ut));
    scl_round_stage #(.IN_W(8), .OUT_W(8), .MODE(RND_NEAREST), .SIGNED_DATA(1'b1)) u_dut_eq (
        .clk(clk), .reset_n(reset_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(v_eq), .out_data(o_eq));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one strobed sample at a falling edge, then wait until the
    // next falling edge, after the registering rising edge.
    task automatic push(input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset out_valid", int'(v_sn | v_st | v_un | v_ut | v_eq), 0);
        chk("R7 reset out_data", int'(o_sn | o_st | o_un | o_ut), 0);
        reset_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            push(VECS[i].din);
            chk("R1 signed trunc", int'(o_st), int'(VECS[i].st));
            chk("R3 signed nearest", int'(o_sn), int'(VECS[i].sn));
            chk("R2 unsigned trunc", int'(o_ut), int'(VECS[i].ut));
            chk("R4 unsigned nearest", int'(o_un), int'(VECS[i].un));
            chk("R9 equal width pass", int'(o_eq), int'(VECS[i].din));
            chk("R6 valid after strobe", int'(v_sn & v_st & v_un & v_ut & v_eq), 1);
        end

        // Saturation corners.
        push(8'h7F);
        chk("R5 signed clamp 0x7F", int'(o_sn), 31);
        push(8'hFE);
        chk("R5 unsigned clamp 0xFE", int'(o_un), 63);
        push(8'hFF);
        chk("R5 unsigned clamp 0xFF", int'(o_un), 63);
        push(8'h80);
        chk("R5 signed minimum kept", int'(o_sn), 32);

        // Idle cycles with changing data: hold and valid drop.
        push(8'h3A);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'hC5;
        @(negedge clk);
        chk("R6 valid drops", int'(v_sn | v_st | v_un | v_ut | v_eq), 0);
        chk("R8 hold signed nearest", int'(o_sn), 15);
        chk("R8 hold unsigned trunc", int'(o_ut), 14);
        in_data = 8'h7F;
        @(negedge clk);
        chk("R8 hold equal width", int'(o_eq), 8'h3A);

        // Mid-stream reset.
        push(8'h55);
        reset_n = 1'b0;
        @(negedge clk);
        chk("R7 mid reset valid", int'(v_sn | v_st | v_un | v_ut | v_eq), 0);
        chk("R7 mid reset data", int'(o_sn | o_st | o_un | o_ut | o_eq), 0);
        in_valid = 1'b0;
        reset_n  = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule